// File: doc/BRIEF.md
# Endpoint Interrupt Flag Controller

This block keeps the interrupt flag byte and the matching enable byte for each endpoint of a USB device controller (five by default). Hardware events from the endpoint engines set flags. The CPU clears a flag by writing a zero over it. The CPU reaches one endpoint at a time: it first writes an endpoint number into a select register, and then its flag, enable and flow-error writes go to that endpoint. The flag readback port shows that endpoint's flags.

Each endpoint has a pending bit in a summary vector. Any event on the endpoint sets it, and a CPU flag write that leaves the endpoint with no flags clears it. The endpoint flags are masked by their enables and combined into one shared endpoint interrupt line. A separate pair of registers, one for device-level flags and one for their enables, drives a general interrupt line. A global enable bit gates both lines.

Top module: `ep_irq_ctrl`

## Requirements
- R1: After reset the following are all zero: every flag, enable, flow-error flag, summary bit, device flag and device enable, the selection and the global enable. Both interrupt lines are low.
- R2: A flag write (`flag_we`) clears each stored flag of the selected endpoint that is 1 and is written as 0. Writing 1 never sets a flag. The written value of bit 5 has no effect. The flag bits, from bit 0 up, are: 0 transmit-ready, 1 stalled, 2 receive-OUT, 3 receive-setup, 4 NAK-OUT, 5 transfer-allowed (read only), 6 NAK-IN, 7 FIFO-control.
- R3: A flag write that clears receive-setup (bit 3) also sets transmit-ready (bit 0) and clears receive-OUT (bit 2) in the same cycle.
- R4: Bit 5 of `flag_rd` is computed from the live inputs. For an IN endpoint (`ep_is_in`=1) it equals NOT `fifo_full`. For an OUT endpoint it equals NOT `fifo_empty`.
- R5: An event on an endpoint sets its `summary` bit one cycle later. The event can be any of flag bits 0-4, 6 or 7, an overflow or an underflow. Bit 5 of `hw_ep_evt` is ignored. A flag write that leaves the endpoint's flags all zero clears the summary bit, unless an event for that endpoint arrives in the same cycle.
- R6: `ep_irq` is high when the global enable is set and, for some endpoint, a flag at bit 0, 1, 2, 3, 4 or 6 is set together with its same-position enable bit. Flag bit 7 never raises the line.
- R7: Overflow and underflow events set per-endpoint flags, read on `flow_rd` bits 0 and 1. A `flow_we` write clears each of these flags that is set and written as 0. Either flag raises `ep_irq` only when enable bit 7 of its endpoint is set.
- R8: Device flags exist at bit 0 (suspend), 2 (start-of-frame), 3 (end-of-reset), 4 (wakeup), 5 (end-of-resume) and 6 (upstream-resume). Events on bits 1 and 7 are ignored. A `dev_flag_we` write clears set bits written as 0. `gen_irq` is high when a device flag and its same-position `dev_en` bit are both set.
- R9: `usb_en` is loaded from bit 7 of `cpu_wdata` on `ctrl_we`. While it is 0, both `ep_irq` and `gen_irq` are low.
- R10: A select write with a value of NUM_EP or more is ignored, and the previous selection is kept.
- R11: When a hardware event and a CPU clear hit the same flag in the same cycle, the flag ends up set. This holds for endpoint, flow-error and device flags.
- R12: Enable, flag and flow-error writes affect only the selected endpoint. `en_rd` and `flow_rd` show the selected endpoint.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_wdata | input | 8 | CPU write data shared by all write strobes |
| sel_we | input | 1 | Write the endpoint select register |
| flag_we | input | 1 | Clear-on-zero write to the selected endpoint's flags |
| en_we | input | 1 | Write the selected endpoint's enable byte |
| flow_we | input | 1 | Clear-on-zero write to the selected endpoint's overflow (bit 0) and underflow (bit 1) flags |
| dev_flag_we | input | 1 | Clear-on-zero write to the device flags |
| dev_en_we | input | 1 | Write the device enable byte |
| ctrl_we | input | 1 | Write the control register (bit 7 is the global enable) |
| hw_ep_evt | input | NUM_EP*8 | Per-endpoint flag set pulses, 8 bits per endpoint with endpoint 0 lowest |
| hw_ovf_evt | input | NUM_EP | Per-endpoint overflow pulses |
| hw_unf_evt | input | NUM_EP | Per-endpoint underflow pulses |
| hw_dev_evt | input | 8 | Device-level flag set pulses |
| ep_is_in | input | NUM_EP | Endpoint direction, 1 = IN |
| fifo_full | input | NUM_EP | Endpoint FIFO full |
| fifo_empty | input | NUM_EP | Endpoint FIFO empty |
| sel_q | output | SEL_W | Selected endpoint |
| flag_rd | output | 8 | Selected endpoint flags with live bit 5 |
| en_rd | output | 8 | Selected endpoint enable byte |
| flow_rd | output | 2 | Selected endpoint overflow and underflow flags |
| summary | output | NUM_EP | Per-endpoint pending bits |
| dev_flags | output | 8 | Device flags |
| dev_en | output | 8 | Device enable byte |
| usb_en | output | 1 | Global enable |
| ep_irq | output | 1 | Shared endpoint interrupt |
| gen_irq | output | 1 | General device interrupt |

## Verification
The hardest situation to reach is a setup acknowledge that lands in the same cycle as a hardware receive-OUT set on the same endpoint. In that cycle the side effect tries to clear receive-OUT while the event tries to set it. A directed step arranges exactly this collision. A long random phase then issues writes and events together, including select writes out of range. The bench's behavioural model predicts every output on every clock, so a collision between side effects, a summary clear or an out-of-range selection that the random phase happens to produce is also caught.

// File: rtl/ep_irq_pkg.sv
package ep_irq_pkg;
    localparam int FLAG_W     = 8;
    localparam int B_TXRDY    = 0;
    localparam int B_STALL    = 1;
    localparam int B_RXOUT    = 2;
    localparam int B_RXSETUP  = 3;
    localparam int B_NAKOUT   = 4;
    localparam int B_XFEROK   = 5;
    localparam int B_NAKIN    = 6;
    localparam int B_FIFOCTL  = 7;
    localparam int EN_FLOWERR = 7;
    localparam int CTRL_GLOBAL = 7;

    // bits that are stored as flags (transfer-allowed is computed on read)
    localparam logic [FLAG_W-1:0] STORE_MASK = 8'hDF;
    // bits that act as interrupt sources
    localparam logic [FLAG_W-1:0] IRQ_MASK   = 8'h5F;
    // device-level flag positions
    localparam logic [FLAG_W-1:0] DEV_MASK   = 8'h7D;

    // a written 0 over a set bit clears it; a written 1 keeps the stored value
    function automatic logic [FLAG_W-1:0] clear_on_zero(
        input logic [FLAG_W-1:0] cur,
        input logic [FLAG_W-1:0] wd
    );
        return cur & wd;
    endfunction
endpackage

// File: rtl/ep_sel_reg.sv
module ep_sel_reg #(
    parameter int NUM_EP = 5,
    localparam int SEL_W = (NUM_EP > 1) ? $clog2(NUM_EP) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sel_we,
    input  logic [7:0]       wdata,
    output logic [SEL_W-1:0] sel
);
    logic in_range;

    always_comb begin
        in_range = (int'(wdata) < NUM_EP);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel <= '0;
        end else if (sel_we && in_range) begin
            sel <= wdata[SEL_W-1:0];
        end
    end
endmodule

// File: rtl/ep_flag_bank.sv
module ep_flag_bank
    import ep_irq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [FLAG_W-1:0] evt,
    input  logic              ovf_evt,
    input  logic              unf_evt,
    input  logic              flag_we,
    input  logic              flow_we,
    input  logic              en_we,
    input  logic [FLAG_W-1:0] wdata,
    output logic [FLAG_W-1:0] flags,
    output logic [FLAG_W-1:0] en,
    output logic              ovf,
    output logic              unf,
    output logic              sum,
    output logic              irq_req
);
    logic [FLAG_W-1:0] flags_nxt;
    logic              ovf_nxt;
    logic              unf_nxt;
    logic              sum_nxt;
    logic              evt_any;
    logic              setup_ack;

    always_comb begin
        setup_ack = flag_we && flags[B_RXSETUP] && !wdata[B_RXSETUP];
        flags_nxt = flags;
        if (flag_we) begin
            flags_nxt = clear_on_zero(flags, wdata);
        end
        if (setup_ack) begin
            flags_nxt[B_TXRDY] = 1'b1;
            flags_nxt[B_RXOUT] = 1'b0;
        end
        // hardware sets applied last: a same-cycle set beats any clear
        flags_nxt = (flags_nxt | evt) & STORE_MASK;

        ovf_nxt = (ovf & !(flow_we && !wdata[0])) | ovf_evt;
        unf_nxt = (unf & !(flow_we && !wdata[1])) | unf_evt;

        evt_any = (|(evt & STORE_MASK)) | ovf_evt | unf_evt;
        if (evt_any) begin
            sum_nxt = 1'b1;
        end else if (flag_we && (flags_nxt == '0)) begin
            sum_nxt = 1'b0;
        end else begin
            sum_nxt = sum;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flags <= '0;
            en    <= '0;
            ovf   <= 1'b0;
            unf   <= 1'b0;
            sum   <= 1'b0;
        end else begin
            flags <= flags_nxt;
            ovf   <= ovf_nxt;
            unf   <= unf_nxt;
            sum   <= sum_nxt;
            if (en_we) begin
                en <= wdata;
            end
        end
    end

    always_comb begin
        irq_req = (|(flags & en & IRQ_MASK)) | (en[EN_FLOWERR] & (ovf | unf));
    end
endmodule

// File: rtl/dev_flag_reg.sv
module dev_flag_reg
    import ep_irq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [FLAG_W-1:0] evt,
    input  logic              flag_we,
    input  logic              en_we,
    input  logic [FLAG_W-1:0] wdata,
    output logic [FLAG_W-1:0] flags,
    output logic [FLAG_W-1:0] en,
    output logic              irq_req
);
    logic [FLAG_W-1:0] flags_nxt;

    always_comb begin
        flags_nxt = flag_we ? clear_on_zero(flags, wdata) : flags;
        flags_nxt = (flags_nxt | evt) & DEV_MASK;
        irq_req   = |(flags & en & DEV_MASK);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flags <= '0;
            en    <= '0;
        end else begin
            flags <= flags_nxt;
            if (en_we) begin
                en <= wdata;
            end
        end
    end
endmodule

// File: rtl/ep_irq_ctrl.sv
module ep_irq_ctrl
    import ep_irq_pkg::*;
#(
    parameter int NUM_EP = 5,
    localparam int SEL_W = (NUM_EP > 1) ? $clog2(NUM_EP) : 1,
    localparam int EVT_W = NUM_EP * FLAG_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [7:0]        cpu_wdata,
    input  logic              sel_we,
    input  logic              flag_we,
    input  logic              en_we,
    input  logic              flow_we,
    input  logic              dev_flag_we,
    input  logic              dev_en_we,
    input  logic              ctrl_we,
    input  logic [EVT_W-1:0]  hw_ep_evt,
    input  logic [NUM_EP-1:0] hw_ovf_evt,
    input  logic [NUM_EP-1:0] hw_unf_evt,
    input  logic [7:0]        hw_dev_evt,
    input  logic [NUM_EP-1:0] ep_is_in,
    input  logic [NUM_EP-1:0] fifo_full,
    input  logic [NUM_EP-1:0] fifo_empty,
    output logic [SEL_W-1:0]  sel_q,
    output logic [7:0]        flag_rd,
    output logic [7:0]        en_rd,
    output logic [1:0]        flow_rd,
    output logic [NUM_EP-1:0] summary,
    output logic [7:0]        dev_flags,
    output logic [7:0]        dev_en,
    output logic              usb_en,
    output logic              ep_irq,
    output logic              gen_irq
);
    logic [FLAG_W-1:0] fl_a  [NUM_EP];
    logic [FLAG_W-1:0] en_a  [NUM_EP];
    logic [NUM_EP-1:0] ovf_v;
    logic [NUM_EP-1:0] unf_v;
    logic [NUM_EP-1:0] req_v;
    logic              dev_req;

    ep_sel_reg #(.NUM_EP(NUM_EP)) u_sel (
        .clk    (clk),
        .rst_n  (rst_n),
        .sel_we (sel_we),
        .wdata  (cpu_wdata),
        .sel    (sel_q)
    );

    for (genvar e = 0; e < NUM_EP; e++) begin : g_ep
        logic hit;
        assign hit = (int'(sel_q) == e);
        ep_flag_bank u_bank (
            .clk     (clk),
            .rst_n   (rst_n),
            .evt     (hw_ep_evt[e*FLAG_W +: FLAG_W]),
            .ovf_evt (hw_ovf_evt[e]),
            .unf_evt (hw_unf_evt[e]),
            .flag_we (flag_we && hit),
            .flow_we (flow_we && hit),
            .en_we   (en_we && hit),
            .wdata   (cpu_wdata),
            .flags   (fl_a[e]),
            .en      (en_a[e]),
            .ovf     (ovf_v[e]),
            .unf     (unf_v[e]),
            .sum     (summary[e]),
            .irq_req (req_v[e])
        );
    end

    dev_flag_reg u_dev (
        .clk     (clk),
        .rst_n   (rst_n),
        .evt     (hw_dev_evt),
        .flag_we (dev_flag_we),
        .en_we   (dev_en_we),
        .wdata   (cpu_wdata),
        .flags   (dev_flags),
        .en      (dev_en),
        .irq_req (dev_req)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            usb_en <= 1'b0;
        end else if (ctrl_we) begin
            usb_en <= cpu_wdata[CTRL_GLOBAL];
        end
    end

    always_comb begin
        flag_rd = fl_a[sel_q];
        flag_rd[B_XFEROK] = ep_is_in[sel_q] ? !fifo_full[sel_q] : !fifo_empty[sel_q];
        en_rd   = en_a[sel_q];
        flow_rd = {unf_v[sel_q], ovf_v[sel_q]};
        ep_irq  = usb_en && (|req_v);
        gen_irq = usb_en && dev_req;
    end
endmodule

// File: rtl/ep_irq_ctrl_chk.sv
module ep_irq_ctrl_chk #(
    parameter int NUM_EP = 5,
    parameter int SEL_W = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic [7:0]        cpu_wdata,
    input logic              sel_we,
    input logic              flag_we,
    input logic              dev_en_we,
    input logic              ctrl_we,
    input logic [NUM_EP*8-1:0] hw_ep_evt,
    input logic [NUM_EP-1:0] hw_ovf_evt,
    input logic [7:0]        hw_dev_evt,
    input logic [SEL_W-1:0]  sel_q,
    input logic [7:0]        flag_rd,
    input logic [NUM_EP-1:0] summary,
    input logic [7:0]        dev_en,
    input logic              usb_en,
    input logic              ep_irq,
    input logic              gen_irq
);
    logic [7:0] sel_evt;
    always_comb begin
        sel_evt = (int'(sel_q) < NUM_EP) ? hw_ep_evt[int'(sel_q)*8 +: 8] : 8'h00;
    end

    AST_SEL_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        int'(sel_q) < NUM_EP); // R10
    AST_SEL_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        sel_we && (int'(cpu_wdata) >= NUM_EP) |=> sel_q == $past(sel_q)); // R10
    AST_IRQ_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        !usb_en |-> !ep_irq && !gen_irq); // R9
    AST_SUM_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (|hw_ovf_evt) |=> (summary & $past(hw_ovf_evt)) == $past(hw_ovf_evt)); // R5
    AST_SETUP_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        flag_we && !sel_we && flag_rd[3] && !cpu_wdata[3] |=> flag_rd[0]); // R3
    AST_NO_WRITE_SET: assert property (@(posedge clk) disable iff (!rst_n)
        flag_we && !sel_we && !flag_rd[6] && !sel_evt[6] |=> !flag_rd[6]); // R2
    AST_GEN_RAISE: assert property (@(posedge clk) disable iff (!rst_n)
        usb_en && !ctrl_we && !dev_en_we && ((hw_dev_evt & dev_en & 8'h7D) != 8'h00)
        |=> gen_irq); // R8
endmodule

bind ep_irq_ctrl ep_irq_ctrl_chk #(.NUM_EP(NUM_EP), .SEL_W(SEL_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cpu_wdata  (cpu_wdata),
    .sel_we     (sel_we),
    .flag_we    (flag_we),
    .dev_en_we  (dev_en_we),
    .ctrl_we    (ctrl_we),
    .hw_ep_evt  (hw_ep_evt),
    .hw_ovf_evt (hw_ovf_evt),
    .hw_dev_evt (hw_dev_evt),
    .sel_q      (sel_q),
    .flag_rd    (flag_rd),
    .summary    (summary),
    .dev_en     (dev_en),
    .usb_en     (usb_en),
    .ep_irq     (ep_irq),
    .gen_irq    (gen_irq)
);

// File: tb/tb_ep_irq_ctrl.sv
`timescale 1ns/1ps
module tb_ep_irq_ctrl;
    localparam int N = 5;
    localparam int SW = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [7:0] cpu_wdata = '0;
    logic sel_we = 0, flag_we = 0, en_we = 0, flow_we = 0;
    logic dev_flag_we = 0, dev_en_we = 0, ctrl_we = 0;
    logic [N*8-1:0] hw_ep_evt = '0;
    logic [N-1:0] hw_ovf_evt = '0, hw_unf_evt = '0;
    logic [7:0] hw_dev_evt = '0;
    logic [N-1:0] ep_is_in = '0, fifo_full = '0, fifo_empty = '1;
    logic [SW-1:0] sel_q;
    logic [7:0] flag_rd, en_rd, dev_flags, dev_en;
    logic [1:0] flow_rd;
    logic [N-1:0] summary;
    logic usb_en, ep_irq, gen_irq;

    always #2 clk = ~clk;

    ep_irq_ctrl #(.NUM_EP(N)) dut (.*);

    // behavioural reference state
    bit [7:0] m_fl [N];
    bit [7:0] m_en [N];
    bit m_ovf [N];
    bit m_unf [N];
    bit m_sum [N];
    int m_sel;
    bit [7:0] m_dfl, m_den;
    bit m_gen_on;

    int checks = 0;
    int fails = 0;
    bit done = 0;

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic model_reset();
        for (int e = 0; e < N; e++) begin
            m_fl[e] = 0; m_en[e] = 0; m_ovf[e] = 0; m_unf[e] = 0; m_sum[e] = 0;
        end
        m_sel = 0; m_dfl = 0; m_den = 0; m_gen_on = 0;
    endtask

    task automatic model_step();
        int cur = m_sel;
        for (int e = 0; e < N; e++) begin
            bit [7:0] ev = hw_ep_evt[e*8 +: 8];
            bit [7:0] f = m_fl[e];
            bit any;
            if (flag_we && e == cur) begin
                bit ack = f[3] && !cpu_wdata[3];
                for (int b = 0; b < 8; b++) if (f[b] && !cpu_wdata[b]) f[b] = 0;
                if (ack) begin f[0] = 1; f[2] = 0; end
            end
            for (int b = 0; b < 8; b++) if (b != 5 && ev[b]) f[b] = 1;
            f[5] = 0;
            any = ((ev & 8'hDF) != 0) || hw_ovf_evt[e] || hw_unf_evt[e];
            if (any) m_sum[e] = 1;
            else if (flag_we && e == cur && f == 0) m_sum[e] = 0;
            m_fl[e] = f;
            if (flow_we && e == cur) begin
                if (!cpu_wdata[0]) m_ovf[e] = 0;
                if (!cpu_wdata[1]) m_unf[e] = 0;
            end
            if (hw_ovf_evt[e]) m_ovf[e] = 1;
            if (hw_unf_evt[e]) m_unf[e] = 1;
            if (en_we && e == cur) m_en[e] = cpu_wdata;
        end
        if (dev_flag_we) m_dfl = m_dfl & cpu_wdata;
        for (int b = 0; b < 8; b++) if (hw_dev_evt[b] && b != 1 && b != 7) m_dfl[b] = 1;
        if (dev_en_we) m_den = cpu_wdata;
        if (ctrl_we) m_gen_on = cpu_wdata[7];
        if (sel_we && cpu_wdata < N) m_sel = cpu_wdata;
    endtask

    task automatic compare_all();
        bit [7:0] exp_rd = m_fl[m_sel];
        bit eirq = 0;
        int sumv = 0;
        exp_rd[5] = ep_is_in[m_sel] ? !fifo_full[m_sel] : !fifo_empty[m_sel];
        for (int e = 0; e < N; e++) begin
            if ((m_fl[e] & m_en[e] & 8'h5F) != 0) eirq = 1;
            if (m_en[e][7] && (m_ovf[e] || m_unf[e])) eirq = 1;
            if (m_sum[e]) sumv = sumv | (1 << e);
        end
        chk("R10 sel", int'(sel_q), m_sel);
        chk("R2 R3 R4 flags", int'(flag_rd), int'(exp_rd));
        chk("R12 enable", int'(en_rd), int'(m_en[m_sel]));
        chk("R7 flow", int'(flow_rd), int'({m_unf[m_sel], m_ovf[m_sel]}));
        chk("R5 summary", int'(summary), sumv);
        chk("R8 devflags", int'(dev_flags), int'(m_dfl));
        chk("R8 deven", int'(dev_en), int'(m_den));
        chk("R9 usb_en", int'(usb_en), int'(m_gen_on));
        chk("R6 ep_irq", int'(ep_irq), int'(m_gen_on && eirq));
        chk("R8 gen_irq", int'(gen_irq), int'(m_gen_on && ((m_dfl & m_den) != 0)));
    endtask

    task automatic cyc();
        model_step();
        @(posedge clk);
        @(negedge clk);
        compare_all();
        sel_we = 0; flag_we = 0; en_we = 0; flow_we = 0;
        dev_flag_we = 0; dev_en_we = 0; ctrl_we = 0;
        hw_ep_evt = '0; hw_ovf_evt = '0; hw_unf_evt = '0; hw_dev_evt = '0;
    endtask

    task automatic wr(input int kind, input bit [7:0] d);
        cpu_wdata = d;
        case (kind)
            0: sel_we = 1;
            1: flag_we = 1;
            2: en_we = 1;
            3: flow_we = 1;
            4: dev_flag_we = 1;
            5: dev_en_we = 1;
            default: ctrl_we = 1;
        endcase
        cyc();
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        model_reset();
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        compare_all();
        chk("R1 reset flags", int'(flag_rd & 8'hDF), 0);
        chk("R1 reset irq", int'({ep_irq, gen_irq}), 0);

        wr(6, 8'h80);
        wr(0, 8'd1);
        wr(2, 8'hFF);
        hw_ep_evt[1*8 + 2] = 1; cyc();
        chk("R5 summary set", int'(summary[1]), 1);
        chk("R6 irq raised", int'(ep_irq), 1);
        wr(1, 8'hFF);
        chk("R2 write ones keeps", int'(flag_rd[2]), 1);
        wr(1, 8'hFB);
        chk("R2 cleared", int'(flag_rd[2]), 0);
        chk("R5 summary cleared", int'(summary[1]), 0);

        hw_ep_evt[1*8 + 3] = 1; hw_ep_evt[1*8 + 2] = 1; cyc();
        wr(1, 8'hF7);
        chk("R3 txrdy set", int'(flag_rd[0]), 1);
        chk("R3 rxout cleared", int'(flag_rd[2]), 0);

        hw_ep_evt[1*8 + 3] = 1; cyc();
        hw_ep_evt[1*8 + 2] = 1; cpu_wdata = 8'hF7; flag_we = 1; cyc();
        chk("R11 set beats clear", int'(flag_rd[2]), 1);

        ep_is_in[1] = 1; fifo_full[1] = 0; @(negedge clk);
        chk("R4 in not full", int'(flag_rd[5]), 1);
        fifo_full[1] = 1; @(negedge clk);
        chk("R4 in full", int'(flag_rd[5]), 0);
        ep_is_in[1] = 0; fifo_empty[1] = 0; @(negedge clk);
        chk("R4 out not empty", int'(flag_rd[5]), 1);
        wr(1, 8'h00);

        wr(0, 8'd5);
        chk("R10 ignore 5", int'(sel_q), 1);
        wr(0, 8'd7);
        chk("R10 ignore 7", int'(sel_q), 1);
        wr(0, 8'd4);
        chk("R10 accept 4", int'(sel_q), 4);

        hw_ovf_evt[4] = 1; cyc();
        chk("R7 ovf flag", int'(flow_rd), 1);
        chk("R7 gated off", int'(ep_irq), 0);
        wr(2, 8'h80);
        chk("R7 gated on", int'(ep_irq), 1);
        wr(3, 8'h02);
        chk("R7 cleared", int'(flow_rd), 0);
        chk("R7 irq drop", int'(ep_irq), 0);

        wr(5, 8'h04);
        hw_dev_evt = 8'h82; cyc();
        chk("R8 reserved ignored", int'(dev_flags), 0);
        hw_dev_evt = 8'h04; cyc();
        chk("R8 sof raise", int'(gen_irq), 1);
        wr(6, 8'h00);
        chk("R9 gate off", int'({ep_irq, gen_irq}), 0);

        wr(0, 8'd2);
        wr(2, 8'h11);
        chk("R12 ep2 enable", int'(en_rd), 8'h11);
        wr(0, 8'd3);
        chk("R12 ep3 untouched", int'(en_rd), 0);

        for (int i = 0; i < 4000; i++) begin
            cpu_wdata = 8'($urandom);
            if ($urandom_range(0, 7) == 0) cpu_wdata = 8'($urandom_range(0, 7));
            sel_we = ($urandom_range(0, 9) == 0);
            flag_we = ($urandom_range(0, 3) == 0);
            en_we = ($urandom_range(0, 9) == 0);
            flow_we = ($urandom_range(0, 7) == 0);
            dev_flag_we = ($urandom_range(0, 5) == 0);
            dev_en_we = ($urandom_range(0, 11) == 0);
            ctrl_we = ($urandom_range(0, 15) == 0);
            for (int k = 0; k < N * 8; k++) hw_ep_evt[k] = ($urandom_range(0, 19) == 0);
            for (int k = 0; k < N; k++) begin
                hw_ovf_evt[k] = ($urandom_range(0, 29) == 0);
                hw_unf_evt[k] = ($urandom_range(0, 29) == 0);
            end
            hw_dev_evt = 8'($urandom) & 8'($urandom) & 8'($urandom);
            ep_is_in = N'($urandom);
            fifo_full = N'($urandom);
            fifo_empty = N'($urandom);
            cyc();
        end

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule